// File: doc/BRIEF.md
# Four-Error ECC Correction Sequencer

This block steps a sector of 512 data bytes through the correction phase of an external four-symbol error-correcting decoder. It is given the ten check bytes stored with the sector. First it tests whether the sector is blank, which means every check byte reads 0xFF. If the sector is not blank, it splits the check bytes into eight 10-bit symbols and feeds them to the decoder, last symbol first. It then looks at the four syndrome words that come back.

When the syndrome words are non-zero, the sequencer pulses a locate request and waits for the decoder's 4-bit state code. If the decoder stays busy for too long, the sequencer gives up. When the decoder reports correctable errors, the sequencer reads up to four address/value pairs and turns each address into a byte position in the sector. For every position that lies inside the sector it issues one XOR-fix command. It finishes with a one-cycle done pulse, a 2-bit result and the number of bytes fixed.

The syndrome and locator arithmetic stay outside the block, behind plain ports.

Top module: `ecc4_corr_seq`

## Requirements
- R1: When a start arrives while idle and all ten check bytes are 0xFF, the next cycle shows done with result clean (2'b00) and count 0. No symbol is loaded and no locate request is made.
- R2: The check bytes form an 80-bit little-endian stream with byte 0 at bits 7:0. Symbol i is stream bits 10*i+9 down to 10*i.
- R3: Symbols go out on the load port one per cycle, in eight consecutive cycles, in the order 7, 6, ..., 0.
- R4: When all four syndrome words are zero after loading, the block reports done, clean, count 0 and makes no locate request.
- R5: The locate request is a one-cycle pulse issued two cycles after the last load. After it, decoder state 0 ends the run as clean, and any state of 4 or above is treated as busy.
- R6: Decoder state 1 ends the run as uncorrectable (2'b10) with count 0.
- R7: Decoder state 2 or 3 means correctable, with the number of pairs equal to the 2-bit count field plus one. Pairs 0 and 1 come from register A and pairs 2 and 3 from register B. Even pairs use address bits 9:0 and value bits 7:0. Odd pairs use address bits 25:16 and value bits 23:16.
- R8: Each address maps to byte index 519 minus the address. Only addresses from 8 to 519, which give indices 0 to 511, produce a fix command and count towards the result. The run ends as corrected (2'b01).
- R9: If the decoder stays busy for TIMEOUT consecutive sampled cycles, the run ends as uncorrectable. Done appears TIMEOUT cycles after the locate pulse.
- R10: Done is a single-cycle pulse, and the count never exceeds four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin correction of one sector |
| check_bytes | input | 80 | Stored check bytes, byte 0 in bits 7:0 |
| syn_words | input | 128 | Four 32-bit syndrome words from the decoder |
| dec_state | input | 4 | Decoder locate state code |
| dec_cnt | input | 2 | Error count field (pairs minus one) |
| err_addr_a | input | 32 | Address register for pairs 0 and 1 |
| err_addr_b | input | 32 | Address register for pairs 2 and 3 |
| err_val_a | input | 32 | Value register for pairs 0 and 1 |
| err_val_b | input | 32 | Value register for pairs 2 and 3 |
| load_valid | output | 1 | Symbol load strobe |
| load_data | output | 10 | Symbol being loaded |
| loc_start | output | 1 | One-cycle locate request |
| fix_valid | output | 1 | XOR-fix command strobe |
| fix_index | output | 9 | Sector byte to fix |
| fix_mask | output | 8 | XOR mask for that byte |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| err_count | output | 3 | Number of bytes fixed |

## Verification
The hardest outcomes to reach are a locate that runs out of time and a correctable report whose addresses fall partly outside the sector. A real decoder seldom produces either. The bench therefore replaces the decoder with a stub that holds a busy code for a chosen delay, or indefinitely, and then presents a programmed state code, count field and address registers. Those registers hold addresses at both ends of the valid range and just beyond it, so the filter and the upper/lower half selection are both exercised.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;
  typedef enum logic [1:0] {
    RES_CLEAN  = 2'b00,
    RES_FIXED  = 2'b01,
    RES_UNCORR = 2'b10
  } res_t;

  typedef enum logic [1:0] {
    V_BUSY,
    V_CLEAN,
    V_FAIL,
    V_FIX
  } verdict_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DRAIN,
    ST_SYN,
    ST_WAIT,
    ST_FIX
  } seq_state_t;
endpackage

// File: rtl/ecc4_unpack.sv
module ecc4_unpack #(
  parameter int SYM_BITS = 10,
  parameter int NUM_SYM  = 8,
  localparam int SEL_W   = $clog2(NUM_SYM),
  localparam int STREAM_W = SYM_BITS * NUM_SYM
) (
  input  logic [STREAM_W-1:0] stream,
  input  logic [SEL_W-1:0]    sel,
  output logic [SYM_BITS-1:0] sym
);
  logic [SYM_BITS-1:0] sym_arr [NUM_SYM];

  for (genvar i = 0; i < NUM_SYM; i++) begin : g_slice
    assign sym_arr[i] = stream[i*SYM_BITS +: SYM_BITS];
  end

  assign sym = sym_arr[sel];
endmodule

// File: rtl/ecc4_status_wait.sv
module ecc4_status_wait
  import ecc4_pkg::*;
#(
  parameter int TIMEOUT = 1024,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     active,
  input  logic [3:0] dec_state,
  output verdict_t verdict
);
  logic [CW-1:0] wait_cnt;

  always_comb begin
    case (dec_state)
      4'd0:       verdict = V_CLEAN;
      4'd1:       verdict = V_FAIL;
      4'd2, 4'd3: verdict = V_FIX;
      default:    verdict = (wait_cnt == CW'(TIMEOUT - 1)) ? V_FAIL : V_BUSY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !active) wait_cnt <= '0;
    else if (verdict == V_BUSY) wait_cnt <= wait_cnt + 1'b1;
  end
endmodule

// File: rtl/ecc4_pair_map.sv
module ecc4_pair_map #(
  parameter int SECTOR_BYTES = 512,
  parameter int SYM_BITS     = 10,
  parameter int BIAS         = SECTOR_BYTES + 7,
  localparam int IDX_W = $clog2(SECTOR_BYTES),
  localparam int DW    = SYM_BITS + 1
) (
  input  logic [1:0]       pair,
  input  logic [31:0]      addr_a,
  input  logic [31:0]      addr_b,
  input  logic [31:0]      val_a,
  input  logic [31:0]      val_b,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       mask,
  output logic             hit
);
  logic [31:0]         areg, vreg;
  logic [SYM_BITS-1:0] addr;
  logic [DW-1:0]       diff;

  always_comb begin
    areg = pair[1] ? addr_b : addr_a;
    vreg = pair[1] ? val_b : val_a;
    addr = pair[0] ? areg[16 +: SYM_BITS] : areg[0 +: SYM_BITS];
    mask = pair[0] ? vreg[23:16] : vreg[7:0];
    diff = DW'(BIAS) - {1'b0, addr};
    hit  = ({1'b0, addr} <= DW'(BIAS)) && (diff < DW'(SECTOR_BYTES));
    idx  = diff[IDX_W-1:0];
  end
endmodule

// File: rtl/ecc4_corr_seq.sv
module ecc4_corr_seq
  import ecc4_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SYM_BITS     = 10,
  parameter int NUM_SYM      = 8,
  parameter int TIMEOUT      = 1024,
  localparam int CHK_W  = SYM_BITS * NUM_SYM,
  localparam int IDX_W  = $clog2(SECTOR_BYTES),
  localparam int SEL_W  = $clog2(NUM_SYM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CHK_W-1:0]  check_bytes,
  input  logic [127:0]      syn_words,
  input  logic [3:0]        dec_state,
  input  logic [1:0]        dec_cnt,
  input  logic [31:0]       err_addr_a,
  input  logic [31:0]       err_addr_b,
  input  logic [31:0]       err_val_a,
  input  logic [31:0]       err_val_b,
  output logic              load_valid,
  output logic [SYM_BITS-1:0] load_data,
  output logic              loc_start,
  output logic              fix_valid,
  output logic [IDX_W-1:0]  fix_index,
  output logic [7:0]        fix_mask,
  output logic              done,
  output logic [1:0]        result,
  output logic [2:0]        err_count
);
  seq_state_t          state_q;
  logic [CHK_W-1:0]    chk_q;
  logic [SEL_W-1:0]    ld_idx;
  logic [2:0]          n_pairs;
  logic [1:0]          pair_idx;
  logic [2:0]          fixed_cnt;
  logic                busy_q;
  logic [SYM_BITS-1:0] cur_sym;
  verdict_t            verdict;
  logic [IDX_W-1:0]    map_idx;
  logic [7:0]          map_mask;
  logic                map_hit;
  logic [2:0]          next_fixed;

  assign busy_q     = (state_q != ST_IDLE);
  assign next_fixed = fixed_cnt + {2'b00, map_hit};

  ecc4_unpack #(.SYM_BITS(SYM_BITS), .NUM_SYM(NUM_SYM)) u_unpack (
    .stream (chk_q),
    .sel    (ld_idx),
    .sym    (cur_sym)
  );

  ecc4_status_wait #(.TIMEOUT(TIMEOUT)) u_wait (
    .clk       (clk),
    .rst       (rst),
    .active    (state_q == ST_WAIT),
    .dec_state (dec_state),
    .verdict   (verdict)
  );

  ecc4_pair_map #(.SECTOR_BYTES(SECTOR_BYTES), .SYM_BITS(SYM_BITS)) u_map (
    .pair   (pair_idx),
    .addr_a (err_addr_a),
    .addr_b (err_addr_b),
    .val_a  (err_val_a),
    .val_b  (err_val_b),
    .idx    (map_idx),
    .mask   (map_mask),
    .hit    (map_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      chk_q      <= '0;
      ld_idx     <= '0;
      n_pairs    <= '0;
      pair_idx   <= '0;
      fixed_cnt  <= '0;
      load_valid <= 1'b0;
      load_data  <= '0;
      loc_start  <= 1'b0;
      fix_valid  <= 1'b0;
      fix_index  <= '0;
      fix_mask   <= '0;
      done       <= 1'b0;
      result     <= RES_CLEAN;
      err_count  <= '0;
    end else begin
      done       <= 1'b0;
      loc_start  <= 1'b0;
      fix_valid  <= 1'b0;
      load_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (check_bytes == '1) begin
              done      <= 1'b1;
              result    <= RES_CLEAN;
              err_count <= '0;
            end else begin
              chk_q   <= check_bytes;
              ld_idx  <= SEL_W'(NUM_SYM - 1);
              state_q <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          load_valid <= 1'b1;
          load_data  <= cur_sym;
          if (ld_idx == '0) state_q <= ST_DRAIN;
          else ld_idx <= ld_idx - 1'b1;
        end
        ST_DRAIN: state_q <= ST_SYN;
        ST_SYN: begin
          if (syn_words == '0) begin
            done      <= 1'b1;
            result    <= RES_CLEAN;
            err_count <= '0;
            state_q   <= ST_IDLE;
          end else begin
            loc_start <= 1'b1;
            state_q   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          case (verdict)
            V_CLEAN: begin
              done      <= 1'b1;
              result    <= RES_CLEAN;
              err_count <= '0;
              state_q   <= ST_IDLE;
            end
            V_FAIL: begin
              done      <= 1'b1;
              result    <= RES_UNCORR;
              err_count <= '0;
              state_q   <= ST_IDLE;
            end
            V_FIX: begin
              n_pairs   <= {1'b0, dec_cnt} + 3'd1;
              pair_idx  <= '0;
              fixed_cnt <= '0;
              state_q   <= ST_FIX;
            end
            default: ;
          endcase
        end
        ST_FIX: begin
          fix_valid <= map_hit;
          fix_index <= map_idx;
          fix_mask  <= map_mask;
          if ({1'b0, pair_idx} == n_pairs - 3'd1) begin
            done      <= 1'b1;
            result    <= RES_FIXED;
            err_count <= next_fixed;
            state_q   <= ST_IDLE;
          end else begin
            pair_idx  <= pair_idx + 1'b1;
            fixed_cnt <= next_fixed;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc4_corr_seq_chk.sv
module ecc4_corr_seq_chk #(
  parameter int CHK_W = 80
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic [CHK_W-1:0] check_bytes,
  input logic             load_valid,
  input logic             loc_start,
  input logic             fix_valid,
  input logic             done,
  input logic [1:0]       result,
  input logic [2:0]       err_count
);
  logic [3:0] run_q;
  logic [2:0] fixes_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      fixes_q <= '0;
    end else begin
      run_q <= load_valid ? run_q + 1'b1 : 4'd0;
      if (loc_start) fixes_q <= '0;
      else if (fix_valid) fixes_q <= fixes_q + 1'b1;
    end
  end

  // R1
  a_r1_erased_bypass: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && check_bytes == '1) |=> (done && result == 2'b00 && err_count == 3'd0));
  // R3
  a_r3_load_burst: assert property (@(posedge clk) disable iff (rst)
    $fell(load_valid) |-> (run_q == 4'd8));
  // R5
  a_r5_locate_after_load: assert property (@(posedge clk) disable iff (rst)
    loc_start |-> (!$past(load_valid) && $past(load_valid, 2)));
  // R7
  a_r7_fix_bound: assert property (@(posedge clk) disable iff (rst)
    fix_valid |-> (fixes_q < 3'd4));
  // R10
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_count <= 3'd4));
endmodule

bind ecc4_corr_seq ecc4_corr_seq_chk #(.CHK_W(CHK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy_q),
  .check_bytes (check_bytes),
  .load_valid  (load_valid),
  .loc_start   (loc_start),
  .fix_valid   (fix_valid),
  .done        (done),
  .result      (result),
  .err_count   (err_count)
);

// File: tb/test_ecc4_corr_seq.sv
module test_ecc4_corr_seq;
  localparam int TMO = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [79:0]  check_bytes = '0;
  logic [127:0] syn_words = '0;
  logic [3:0]   dec_state = 4'd4;
  logic [1:0]   dec_cnt = '0;
  logic [31:0]  err_addr_a = '0, err_addr_b = '0, err_val_a = '0, err_val_b = '0;
  logic         load_valid, loc_start, fix_valid, done;
  logic [9:0]   load_data;
  logic [8:0]   fix_index;
  logic [7:0]   fix_mask;
  logic [1:0]   result;
  logic [2:0]   err_count;

  int n_checks = 0;
  int n_fail = 0;

  ecc4_corr_seq #(.TIMEOUT(TMO)) i_ecc4_corr_seq (
    .clk, .rst, .start, .check_bytes, .syn_words, .dec_state, .dec_cnt,
    .err_addr_a, .err_addr_b, .err_val_a, .err_val_b,
    .load_valid, .load_data, .loc_start, .fix_valid, .fix_index, .fix_mask,
    .done, .result, .err_count
  );

  always #5ns clk = ~clk;

  // decoder stub
  logic [3:0] stub_final = 4'd0;
  int         stub_delay = 0;
  int         stub_left = 0;
  logic       stub_pend = 1'b0;
  always @(posedge clk) begin
    if (loc_start) begin
      stub_left <= stub_delay;
      stub_pend <= 1'b1;
    end else if (stub_pend) begin
      if (stub_left == 0) begin
        dec_state <= stub_final;
        stub_pend <= 1'b0;
      end else stub_left <= stub_left - 1;
    end
  end

  // output monitor
  logic [9:0] ld_buf [16];
  int         ld_n = 0;
  logic [8:0] fx_idx [8];
  logic [7:0] fx_msk [8];
  int         fx_n = 0;
  int         loc_n = 0;
  int         done_n = 0;
  logic [1:0] res_cap = '0;
  logic [2:0] cnt_cap = '0;
  int         gap = 0;
  int         done_gap = 0;
  always @(negedge clk) begin
    if (load_valid && ld_n < 16) begin ld_buf[ld_n] = load_data; ld_n++; end
    if (fix_valid && fx_n < 8) begin fx_idx[fx_n] = fix_index; fx_msk[fx_n] = fix_mask; fx_n++; end
    if (loc_start) begin loc_n++; gap = 0; end else gap++;
    if (done) begin done_n++; res_cap = result; cnt_cap = err_count; done_gap = gap; end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    ld_n = 0; fx_n = 0; loc_n = 0; done_n = 0;
  endtask

  task automatic run_sector(logic [79:0] cb);
    @(negedge clk);
    clear_mon();
    dec_state   = 4'd4;
    check_bytes = cb;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (done_n != 0) break;
      @(negedge clk);
    end
    if (done_n == 0) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [79:0] pack_syms(logic [9:0] v0, logic [9:0] v1, logic [9:0] v2,
      logic [9:0] v3, logic [9:0] v4, logic [9:0] v5, logic [9:0] v6, logic [9:0] v7);
    return {v7, v6, v5, v4, v3, v2, v1, v0};
  endfunction

  task automatic t_reset();
    check("R10 reset done", int'(done), 0);
    check("R3 reset load_valid", int'(load_valid), 0);
    check("R8 reset fix_valid", int'(fix_valid), 0);
  endtask

  task automatic t_erased();
    run_sector('1);
    check("R1 done count", done_n, 1);
    check("R1 result clean", int'(res_cap), 0);
    check("R1 err_count", int'(cnt_cap), 0);
    check("R1 no loads", ld_n, 0);
    check("R1 no locate", loc_n, 0);
  endtask

  task automatic t_unpack_order();
    logic [9:0] v [8];
    logic [79:0] cb;
    for (int i = 0; i < 8; i++) v[i] = 10'(32'h0A5 + 32'h07B * i);
    cb = pack_syms(v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]);
    syn_words = '0;
    run_sector(cb);
    check("R3 load count", ld_n, 8);
    for (int k = 0; k < 8; k++) check("R2 R3 symbol order", int'(ld_buf[k]), int'(v[7-k]));
    check("R4 syndrome zero result", int'(res_cap), 0);
    check("R4 no locate", loc_n, 0);
  endtask

  task automatic t_near_erased();
    logic [79:0] cb = '1;
    cb[7:0] = 8'hFE;
    syn_words = '0;
    run_sector(cb);
    check("R1 near-erased loads", ld_n, 8);
    check("R2 symbol 0 loaded last", int'(ld_buf[7]), 10'h3FE);
  endtask

  task automatic t_locate_clean();
    syn_words = 128'h1;
    stub_final = 4'd0; stub_delay = 5;
    run_sector(80'h1234);
    check("R5 locate pulses", loc_n, 1);
    check("R5 clean result", int'(res_cap), 0);
    check("R5 no fixes", fx_n, 0);
  endtask

  task automatic t_uncorr();
    syn_words = 128'h8 << 64;
    stub_final = 4'd1; stub_delay = 2;
    run_sector(80'h55);
    check("R6 result uncorrectable", int'(res_cap), 2);
    check("R6 count zero", int'(cnt_cap), 0);
  endtask

  task automatic t_fix_four();
    syn_words = 128'h3;
    stub_final = 4'd3; stub_delay = 1;
    dec_cnt = 2'd3;
    err_addr_a = {16'd8, 16'd519};
    err_val_a  = {8'h00, 8'h80, 8'h00, 8'h01};
    err_addr_b = {16'd600, 16'd7};
    err_val_b  = {8'h00, 8'h44, 8'h00, 8'h22};
    run_sector(80'h99);
    check("R8 fixes emitted", fx_n, 2);
    check("R7 R8 pair0 index", int'(fx_idx[0]), 0);
    check("R7 pair0 mask", int'(fx_msk[0]), 8'h01);
    check("R7 R8 pair1 index upper half", int'(fx_idx[1]), 511);
    check("R7 pair1 mask upper half", int'(fx_msk[1]), 8'h80);
    check("R8 result corrected", int'(res_cap), 1);
    check("R8 count in-range only", int'(cnt_cap), 2);
  endtask

  task automatic t_fix_two();
    syn_words = 128'h1 << 100;
    stub_final = 4'd2; stub_delay = 0;
    dec_cnt = 2'd1;
    err_addr_a = {16'd300, 16'd100};
    err_val_a  = {8'h00, 8'h0F, 8'h00, 8'hF0};
    err_addr_b = {16'd200, 16'd150};
    err_val_b  = {8'h00, 8'h11, 8'h00, 8'h33};
    run_sector(80'h7);
    check("R7 two pairs only", fx_n, 2);
    check("R8 index 519-100", int'(fx_idx[0]), 419);
    check("R8 index 519-300", int'(fx_idx[1]), 219);
    check("R7 mask pair1", int'(fx_msk[1]), 8'h0F);
    check("R7 count two", int'(cnt_cap), 2);
  endtask

  task automatic t_timeout();
    syn_words = 128'h5;
    stub_final = 4'd9; stub_delay = 0;
    run_sector(80'hABC);
    check("R9 result uncorrectable", int'(res_cap), 2);
    check("R9 cycles to done", done_gap, TMO);
    check("R10 single done", done_n, 1);
  endtask

  initial begin
    #1_000_000ns;
    n_checks++; n_fail++;
    $display("FAIL watchdog global actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_erased();
    t_unpack_order();
    t_near_erased();
    t_locate_clean();
    t_uncorr();
    t_fix_four();
    t_fix_two();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule